// File: doc/BRIEF.md
# Chained Multiply-Add Pipeline Unit

This unit pairs an integer multiplier with an integer adder. Each has its own fixed latency and issue rules. The multiplier returns its product five cycles after a multiply is accepted, and it accepts a new multiply at most once every three cycles. The adder returns its result three cycles after issue and can take a new operation on every cycle.

Two routes avoid a round trip through any register file. The current product can be steered straight into either adder operand. The adder's own result register can also be selected as an operand, so it acts as a running partial sum.

A multiply request that arrives too early is held with a busy flag, and the requester keeps it asserted until it is accepted. An accumulate mode wires the two routes together. Each product that emerges is added to the running sum on the cycle it appears. A pass-through adder operation clears the sum beforehand.

Top module: `cmac_unit`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `prod_valid`, `sum_valid` and `mul_busy` are low and `sum_out` is zero.
- R2: A multiply accepted in cycle c gives `prod_out` = `mul_a`*`mul_b` (unsigned, 2W bits) with `prod_valid` high for exactly one cycle, in cycle c+5.
- R3: A multiply is accepted in a cycle where `mul_req` is high and `mul_busy` is low. A request arriving 1 or 2 cycles after the previous acceptance sees `mul_busy` high and is accepted exactly 3 cycles after that acceptance.
- R4: An adder operation issued in cycle c gives its result on `sum_out` with `sum_valid` high in cycle c+3. Issues on consecutive cycles produce results on consecutive cycles.
- R5: `add_op` encodes the operation as 2'b00 for A+B, 2'b01 for A-B (modulo 2^(2W)), and 2'b10 or 2'b11 for pass A (bypass).
- R6: `add_sel_a`=1 selects the product as operand A. `add_sel_b`=2'b01 selects the product as operand B. The product used is the value on `prod_out` in the issue cycle, which is the cycle its `prod_valid` is high.
- R7: `add_sel_b`=2'b10 selects the value on `sum_out` in the issue cycle (the running sum). `add_sel_b`=2'b00 selects port `add_b`, and 2'b11 selects zero. `add_sel_a`=0 selects port `add_a`.
- R8: A bypass of zero followed by a sequence of product-plus-running-sum additions leaves the accumulated sum of products on `sum_out`.
- R9: With `acc_mode` high, every cycle with `prod_valid` high issues an addition of product and running sum. A new product arriving 3 cycles after the previous one sees the previous sum. An `add_req` in that same cycle is dropped.
- R10: `sum_out` keeps its value in every cycle in which `sum_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 1 | Auto-accumulate each product into the running sum |
| mul_req | input | 1 | Multiply request, held until accepted |
| mul_a | input | W | Multiplicand |
| mul_b | input | W | Multiplier operand |
| mul_busy | output | 1 | Request present but held by the issue interval |
| add_req | input | 1 | Adder operation request |
| add_op | input | 2 | Adder operation code |
| add_sel_a | input | 1 | Operand A source: port or product |
| add_sel_b | input | 2 | Operand B source: port, product, running sum, zero |
| add_a | input | 2W | Operand A from port |
| add_b | input | 2W | Operand B from port |
| prod_valid | output | 1 | Product valid pulse |
| prod_out | output | 2W | Product |
| sum_valid | output | 1 | Adder result valid pulse |
| sum_out | output | 2W | Adder result and running sum |

## Verification
The hardest case to reach is accumulate mode at the multiplier's full issue rate. There, the second product shows up on the same cycle the first sum lands. It must pick up that fresh sum, and in the same cycle an external adder request has to lose to the chained one. The stimulus gets there by queueing two multiplies back to back, so the second one is held by the interval gate. The stimulus also drives a bypass request on the exact cycle the first product emerges. The scoreboard then expects only the two chained sums, each at its exact cycle.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  typedef enum logic [1:0] {
    AOP_ADD  = 2'b00,
    AOP_SUB  = 2'b01,
    AOP_PASS = 2'b10,
    AOP_PSS2 = 2'b11
  } aop_e;

  typedef enum logic {
    SA_PORT = 1'b0,
    SA_PROD = 1'b1
  } srca_e;

  typedef enum logic [1:0] {
    SB_PORT = 2'b00,
    SB_PROD = 2'b01,
    SB_FEED = 2'b10,
    SB_ZERO = 2'b11
  } srcb_e;
endpackage

// File: rtl/cmac_gap_gate.sv
module cmac_gap_gate #(
  parameter int II = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept,
  output logic busy
);
  localparam int CW = $clog2(II) + 1;

  logic [CW-1:0] gap;

  assign accept = req && (gap == '0);
  assign busy   = req && (gap != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0;
    end else if (accept) begin
      gap <= CW'(II - 1);
    end else if (gap != '0) begin
      gap <= gap - CW'(1);
    end
  end
endmodule

// File: rtl/cmac_stage_chain.sv
module cmac_stage_chain #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  for (genvar i = 0; i < LAT; i++) begin : g_st
    logic          vin;
    logic [DW-1:0] din;
    logic          v;
    logic [DW-1:0] d;

    if (i == 0) begin : g_head
      assign vin = in_valid;
      assign din = in_data;
    end else begin : g_body
      assign vin = g_st[i-1].v;
      assign din = g_st[i-1].d;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v <= 1'b0;
        d <= '0;
      end else begin
        v <= vin;
        if (vin) d <= din;
      end
    end
  end

  assign out_valid = g_st[LAT-1].v;
  assign out_data  = g_st[LAT-1].d;
endmodule

// File: rtl/cmac_unit.sv
module cmac_unit #(
  parameter int W       = 16,
  parameter int MUL_LAT = 5,
  parameter int MUL_II  = 3,
  parameter int ADD_LAT = 3,
  localparam int PW     = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_mode,
  input  logic          mul_req,
  input  logic [W-1:0]  mul_a,
  input  logic [W-1:0]  mul_b,
  output logic          mul_busy,
  input  logic          add_req,
  input  logic [1:0]    add_op,
  input  logic          add_sel_a,
  input  logic [1:0]    add_sel_b,
  input  logic [PW-1:0] add_a,
  input  logic [PW-1:0] add_b,
  output logic          prod_valid,
  output logic [PW-1:0] prod_out,
  output logic          sum_valid,
  output logic [PW-1:0] sum_out
);
  import cmac_pkg::*;

  logic          mul_go;
  logic [PW-1:0] prod_raw;
  logic          auto_chain;
  logic          add_go;
  aop_e          op_eff;
  logic [PW-1:0] opa;
  logic [PW-1:0] opb;
  logic [PW-1:0] add_raw;

  cmac_gap_gate #(.II(MUL_II)) gate_i (
    .clk    (clk),
    .rst    (rst),
    .req    (mul_req),
    .accept (mul_go),
    .busy   (mul_busy)
  );

  assign prod_raw = {{W{1'b0}}, mul_a} * {{W{1'b0}}, mul_b};

  cmac_stage_chain #(.DW(PW), .LAT(MUL_LAT)) mul_pipe_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (mul_go),
    .in_data   (prod_raw),
    .out_valid (prod_valid),
    .out_data  (prod_out)
  );

  always_comb begin
    auto_chain = acc_mode && prod_valid;
    add_go     = auto_chain || add_req;
    op_eff     = auto_chain ? AOP_ADD : aop_e'(add_op);
    opa        = (auto_chain || (add_sel_a == SA_PROD)) ? prod_out : add_a;
    if (auto_chain) begin
      opb = sum_out;
    end else begin
      case (srcb_e'(add_sel_b))
        SB_PORT: opb = add_b;
        SB_PROD: opb = prod_out;
        SB_FEED: opb = sum_out;
        default: opb = '0;
      endcase
    end
    case (op_eff)
      AOP_ADD: add_raw = opa + opb;
      AOP_SUB: add_raw = opa - opb;
      default: add_raw = opa;
    endcase
  end

  cmac_stage_chain #(.DW(PW), .LAT(ADD_LAT)) add_pipe_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (add_go),
    .in_data   (add_raw),
    .out_valid (sum_valid),
    .out_data  (sum_out)
  );
endmodule

// File: rtl/cmac_unit_chk.sv
module cmac_unit_chk #(
  parameter int W       = 16,
  parameter int MUL_LAT = 5,
  parameter int MUL_II  = 3,
  parameter int ADD_LAT = 3,
  localparam int PW     = 2 * W
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_mode,
  input logic          mul_req,
  input logic          mul_busy,
  input logic          add_req,
  input logic          prod_valid,
  input logic          sum_valid,
  input logic [PW-1:0] sum_out
);
  logic                 macc;
  logic                 aiss;
  logic [MUL_LAT-1:0]   mh;
  logic [ADD_LAT-1:0]   ah;

  assign macc = mul_req && !mul_busy;
  assign aiss = add_req || (acc_mode && prod_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      mh <= '0;
      ah <= '0;
    end else begin
      mh <= (mh << 1) | MUL_LAT'(macc);
      ah <= (ah << 1) | ADD_LAT'(aiss);
    end
  end

  p_mul_lat_r2: assert property (@(posedge clk) disable iff (rst)
    prod_valid == mh[MUL_LAT-1]);

  p_add_lat_r4: assert property (@(posedge clk) disable iff (rst)
    sum_valid == ah[ADD_LAT-1]);

  p_gap_next_r3: assert property (@(posedge clk) disable iff (rst)
    macc |=> !macc);

  p_gap_after_r3: assert property (@(posedge clk) disable iff (rst)
    macc |=> ##1 !macc);

  p_busy_req_r3: assert property (@(posedge clk) disable iff (rst)
    mul_busy |-> mul_req);

  p_sum_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !sum_valid |-> $stable(sum_out));
endmodule

bind cmac_unit cmac_unit_chk #(
  .W(W), .MUL_LAT(MUL_LAT), .MUL_II(MUL_II), .ADD_LAT(ADD_LAT)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .acc_mode   (acc_mode),
  .mul_req    (mul_req),
  .mul_busy   (mul_busy),
  .add_req    (add_req),
  .prod_valid (prod_valid),
  .sum_valid  (sum_valid),
  .sum_out    (sum_out)
);

// File: tb/cmac_unit_tb.sv
module cmac_unit_tb_top;
  localparam int W  = 16;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_mode;
  logic          mul_req;
  logic [W-1:0]  mul_a;
  logic [W-1:0]  mul_b;
  logic          mul_busy;
  logic          add_req;
  logic [1:0]    add_op;
  logic          add_sel_a;
  logic [1:0]    add_sel_b;
  logic [PW-1:0] add_a;
  logic [PW-1:0] add_b;
  logic          prod_valid;
  logic [PW-1:0] prod_out;
  logic          sum_valid;
  logic [PW-1:0] sum_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_mul = 0;
  bit done = 1'b0;

  logic [PW-1:0] mv[$];
  int            mc[$];
  string         mt[$];
  logic [PW-1:0] av[$];
  int            ac[$];
  string         at[$];

  cmac_unit dut_i (
    .clk(clk), .rst(rst), .acc_mode(acc_mode), .mul_req(mul_req),
    .mul_a(mul_a), .mul_b(mul_b), .mul_busy(mul_busy), .add_req(add_req),
    .add_op(add_op), .add_sel_a(add_sel_a), .add_sel_b(add_sel_b),
    .add_a(add_a), .add_b(add_b), .prod_valid(prod_valid),
    .prod_out(prod_out), .sum_valid(sum_valid), .sum_out(sum_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic void chk_at(string tag, logic [PW-1:0] act, logic [PW-1:0] exp,
                                 int c, int ec);
    checks++;
    if (act !== exp || c != ec) begin
      errors++;
      $display("FAIL %s actual %h@%0d expected %h@%0d", tag, act, c, exp, ec);
    end
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (prod_valid) begin
        if (mv.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 actual product %h@%0d expected none", prod_out, cyc);
        end else begin
          chk_at(mt[0], prod_out, mv[0], cyc, mc[0]);
          void'(mv.pop_front()); void'(mc.pop_front()); void'(mt.pop_front());
        end
      end else if (mc.size() > 0 && mc[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s actual none expected %h@%0d", mt[0], mv[0], mc[0]);
        void'(mv.pop_front()); void'(mc.pop_front()); void'(mt.pop_front());
      end
      if (sum_valid) begin
        if (av.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 actual sum %h@%0d expected none", sum_out, cyc);
        end else begin
          chk_at(at[0], sum_out, av[0], cyc, ac[0]);
          void'(av.pop_front()); void'(ac.pop_front()); void'(at.pop_front());
        end
      end else if (ac.size() > 0 && ac[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s actual none expected %h@%0d", at[0], av[0], ac[0]);
        void'(av.pop_front()); void'(ac.pop_front()); void'(at.pop_front());
      end
    end
  end

  task automatic wait_until(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic drive_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input string tag, output int held);
    held = 0;
    mul_req = 1'b1; mul_a = a; mul_b = b;
    #1;
    while (mul_busy) begin
      held++;
      @(negedge clk);
      #1;
    end
    mv.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
    mc.push_back(cyc + 5);
    mt.push_back(tag);
    last_mul = cyc;
    @(negedge clk);
    mul_req = 1'b0;
  endtask

  task automatic drive_add(input logic [1:0] op, input logic sa, input logic [1:0] sb,
                           input logic [PW-1:0] a, input logic [PW-1:0] b,
                           input logic [PW-1:0] exp, input string tag);
    add_req = 1'b1; add_op = op; add_sel_a = sa; add_sel_b = sb;
    add_a = a; add_b = b;
    av.push_back(exp); ac.push_back(cyc + 3); at.push_back(tag);
    @(negedge clk);
    add_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h;
    int k;
    logic [PW-1:0] acc;
    rst = 1'b1; acc_mode = 1'b0; mul_req = 1'b0; mul_a = '0; mul_b = '0;
    add_req = 1'b0; add_op = 2'b00; add_sel_a = 1'b0; add_sel_b = 2'b00;
    add_a = '0; add_b = '0;
    repeat (2) @(negedge clk);
    chk("R1 prod_valid in reset", {31'b0, prod_valid}, 0);
    chk("R1 sum_out in reset", sum_out, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 prod_valid", {31'b0, prod_valid}, 0);
    chk("R1 sum_valid", {31'b0, sum_valid}, 0);
    chk("R1 mul_busy", {31'b0, mul_busy}, 0);
    chk("R1 sum_out", sum_out, 0);

    // R2: products of distinct patterns
    drive_mul(16'd3, 16'd7, "R2", h);
    repeat (4) @(negedge clk);
    drive_mul(16'hFFFF, 16'hFFFF, "R2", h);
    repeat (6) @(negedge clk);

    // R3: back-to-back requests, second held 2 cycles
    drive_mul(16'd2, 16'd2, "R3", h);
    drive_mul(16'd3, 16'd3, "R3", h);
    chk("R3 held cycles", PW'(h), 2);
    repeat (6) @(negedge clk);

    // R4 and R5: consecutive adder issues, each op code
    drive_add(2'b00, 1'b0, 2'b00, 32'd5, 32'd6, 32'd11, "R5 add");
    drive_add(2'b01, 1'b0, 2'b00, 32'd10, 32'd3, 32'd7, "R4 sub back-to-back");
    drive_add(2'b01, 1'b0, 2'b00, 32'd3, 32'd10, 32'hFFFF_FFF9, "R5 sub wrap");
    drive_add(2'b10, 1'b0, 2'b00, 32'h1234, 32'd99, 32'h1234, "R5 pass");
    drive_add(2'b11, 1'b0, 2'b11, 32'h55, 32'd1, 32'h55, "R5 pass alt");
    drive_add(2'b00, 1'b0, 2'b11, 32'h40, 32'h77, 32'h40, "R7 zero select");
    repeat (5) @(negedge clk);

    // R6: chain product into port A, then port B
    drive_mul(16'd100, 16'd200, "R6", h);
    k = last_mul;
    wait_until(k + 5);
    drive_add(2'b00, 1'b1, 2'b00, 32'd0, 32'd5, 32'd20005, "R6 product on A");
    drive_mul(16'd9, 16'd9, "R6", h);
    k = last_mul;
    wait_until(k + 5);
    drive_add(2'b01, 1'b0, 2'b01, 32'd1000, 32'd0, 32'd919, "R6 product on B");
    repeat (5) @(negedge clk);

    // R8: bypass zero then accumulate products through feedback
    drive_add(2'b10, 1'b0, 2'b00, 32'd0, 32'd0, 32'd0, "R8 clear");
    repeat (3) @(negedge clk);
    acc = 0;
    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] xa;
      logic [W-1:0] xb;
      xa = (i == 0) ? 16'd2 : (i == 1) ? 16'd4 : 16'd7;
      xb = (i == 0) ? 16'd3 : (i == 1) ? 16'd5 : 16'd1;
      drive_mul(xa, xb, "R8", h);
      k = last_mul;
      acc = acc + PW'(xa) * PW'(xb);
      wait_until(k + 5);
      drive_add(2'b00, 1'b1, 2'b10, 32'd0, 32'd0, acc, "R8 accumulate");
      repeat (3) @(negedge clk);
    end
    chk("R8 final sum", sum_out, 32'd33);
    drive_add(2'b00, 1'b0, 2'b10, 32'd100, 32'd0, 32'd133, "R7 feedback");
    repeat (4) @(negedge clk);

    // R9: accumulate mode at full multiply rate, external request dropped
    acc_mode = 1'b1;
    drive_add(2'b10, 1'b0, 2'b00, 32'd0, 32'd0, 32'd0, "R9 clear");
    repeat (3) @(negedge clk);
    drive_mul(16'd3, 16'd4, "R9", h);
    k = last_mul;
    drive_mul(16'd5, 16'd5, "R9", h);
    chk("R9 second multiply gap", PW'(last_mul - k), 3);
    av.push_back(32'd12); ac.push_back(k + 8);  at.push_back("R9 first auto sum");
    av.push_back(32'd37); ac.push_back(k + 11); at.push_back("R9 second auto sum");
    wait_until(k + 5);
    add_req = 1'b1; add_op = 2'b10; add_sel_a = 1'b0; add_a = 32'hDEAD;
    @(negedge clk);
    add_req = 1'b0;
    wait_until(k + 13);
    acc_mode = 1'b0;
    chk("R9 sum after auto chain", sum_out, 32'd37);

    // R10: result holds while idle
    repeat (6) @(negedge clk);
    chk("R10 sum held", sum_out, 32'd37);
    chk("R10 no valid", {31'b0, sum_valid}, 0);
    chk("R2 product queue drained", PW'(mv.size()), 0);
    chk("R4 sum queue drained", PW'(av.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule